// File: doc/BRIEF.md
# Two-Stage Mapped Interrupt Controller

This block collects 64 single-bit system event lines and turns them into 10 host interrupt lines for an embedded processor core. Each event passes through a polarity and type stage and is held in a status bit. A programmable event-to-channel map sends it to one of 10 channels, and a second map sends each channel to one of 10 host outputs. A host output rises only when the global enable is on, that host has been enabled, and some enabled, latched event reaches it through both maps.

Software sets up the controller through a 32-bit register port that uses word addresses. It clears status bits by writing ones. It enables a host output by writing that host's number to an index register, not by writing a bit mask, and writing the number of a host that is already enabled fires that output again. The two lowest host outputs are also copied into the two top bits of a status word, so the core can poll them instead of taking the interrupt.

Top module: `mpic_top`

## Requirements
- R1: After reset, every enable is 0, every map field is 0, polarity words (word addresses 8 and 9) read all ones, type words (10 and 11) read 0, status reads 0 and all host outputs are low.
- R2: A polarity bit of 1 makes an event active high and 0 makes it active low. A level-type event (type bit 0) sets its status in every cycle it is at its active level, so clearing it while the level is still active has no lasting effect.
- R3: A pulse-type event (type bit 1) sets its status only on a change from inactive to active. Holding the input active after a clear does not set the status again.
- R4: Status bits stay set until cleared. Writing ones to status words 12 (events 0-31) and 13 (events 32-63) clears those bits, and zero bits have no effect. When a clear and a new event arrive in the same cycle, the status stays set.
- R5: Event n is routed to the channel held in byte (n mod 4) of map word 16 + n/4. A channel is pending when an event routed to it is both latched and enabled in enable words 14 and 15.
- R6: Channel c is routed to the host held in byte (c mod 4) of host-map word 32 + c/4. A host output is high when any pending channel is routed to it.
- R7: An event map value above 9 routes the event to no channel, and a host map value above 9 routes the channel to no host.
- R8: Writing k, in bits 7:0, to word 1 enables host k. Values of 10 or more are ignored. Word 2 reads back the host-enable mask, one bit per host.
- R9: Writing to word 1 the index of a host that is already enabled drives that output low for exactly the one cycle after the write. The output comes back high if the host is still pending.
- R10: Bit 0 of word 0 is the global enable. While it is 0 no host output is high, but event status still latches.
- R11: Status word 3, and the `core_status` port, carry host 0 on bit 30 and host 1 on bit 31. All other bits are 0.
- R12: The polarity, type, enable and map words read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 64 | System event inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| host_irq | output | 10 | Host interrupt outputs |
| core_status | output | 32 | Polled word: host 0 on bit 30, host 1 on bit 31 |

## Verification
Two functions can land on the same clock edge: a write-one-to-clear of a status bit and a new edge on that same event. The bench drives the event's rising input and the clear write at the same negative edge, so the register stage samples both together. It then reads the status word and expects the bit to remain set.

A second collision is an index write that re-triggers a host which is already driving its output. The bench samples that output in the cycle after the write, where it must be low, and again one cycle later, where it must be high.

// File: rtl/mpic_pkg.sv
// Package: shared word addresses and field types of the mapped interrupt controller.
// Assumes word addressing on the register port; event-indexed blocks start at A_EVBASE.
package mpic_pkg;
    localparam int unsigned DW          = 32;
    localparam int unsigned A_GLOBAL    = 0;
    localparam int unsigned A_HIDX      = 1;
    localparam int unsigned A_HEN       = 2;
    localparam int unsigned A_CORE      = 3;
    localparam int unsigned A_EVBASE    = 8;
    localparam int unsigned CORE_BIT_H0 = 30;
    localparam int unsigned CORE_BIT_H1 = 31;
    typedef logic [7:0] map_field_t;
endpackage

// File: rtl/mpic_regs.sv
// Module: register file. Holds global enable, polarity, type, event enables, both maps
// and host enables; produces the status clear mask and the one-cycle re-trigger pulse.
// Assumes NUM_EVENTS is a multiple of 32 and full-word writes.
module mpic_regs
    import mpic_pkg::*;
#(
    parameter int unsigned NUM_EVENTS   = 64,
    parameter int unsigned NUM_CHANNELS = 10,
    parameter int unsigned NUM_HOSTS    = 10,
    parameter int unsigned ADDR_W       = 6
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                reg_wr,
    input  logic [ADDR_W-1:0]                   reg_addr,
    input  logic [DW-1:0]                       reg_wdata,
    output logic [DW-1:0]                       reg_rdata,
    input  logic [NUM_EVENTS-1:0]               status_i,
    input  logic [DW-1:0]                       core_word_i,
    output logic                                glob_en_o,
    output logic [NUM_EVENTS-1:0]               pol_o,
    output logic [NUM_EVENTS-1:0]               type_o,
    output logic [NUM_EVENTS-1:0]               en_o,
    output logic [NUM_EVENTS-1:0]               clr_o,
    output logic [NUM_EVENTS-1:0][7:0]          evmap_o,
    output logic [NUM_CHANNELS-1:0][7:0]        hmap_o,
    output logic [NUM_HOSTS-1:0]                hen_o,
    output logic [NUM_HOSTS-1:0]                retrig_o
);
    localparam int unsigned EV_WORDS = NUM_EVENTS / 32;
    localparam int unsigned A_POL    = A_EVBASE;
    localparam int unsigned A_TYPE   = A_POL + EV_WORDS;
    localparam int unsigned A_STAT   = A_TYPE + EV_WORDS;
    localparam int unsigned A_EN     = A_STAT + EV_WORDS;
    localparam int unsigned A_EVMAP  = A_EN + EV_WORDS;
    localparam int unsigned A_HMAP   = A_EVMAP + NUM_EVENTS / 4;

    logic                         glob_q;
    logic [NUM_EVENTS-1:0]        pol_q, type_q, en_q;
    logic [NUM_EVENTS-1:0][7:0]   evmap_q;
    logic [NUM_CHANNELS-1:0][7:0] hmap_q;
    logic [NUM_HOSTS-1:0]         hen_q, retrig_q;

    // Register writes and the host-enable index set with its re-trigger pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_q   <= 1'b0;
            pol_q    <= '1;
            type_q   <= '0;
            en_q     <= '0;
            evmap_q  <= '0;
            hmap_q   <= '0;
            hen_q    <= '0;
            retrig_q <= '0;
        end else begin
            retrig_q <= '0;
            if (reg_wr) begin
                if (reg_addr == ADDR_W'(A_GLOBAL)) glob_q <= reg_wdata[0];
                if (reg_addr == ADDR_W'(A_HIDX)) begin
                    for (int h = 0; h < NUM_HOSTS; h++) begin
                        if (reg_wdata[7:0] == 8'(h)) begin
                            hen_q[h]    <= 1'b1;
                            retrig_q[h] <= hen_q[h];
                        end
                    end
                end
                for (int w = 0; w < EV_WORDS; w++) begin
                    if (reg_addr == ADDR_W'(A_POL + w))  pol_q[w*32 +: 32]  <= reg_wdata;
                    if (reg_addr == ADDR_W'(A_TYPE + w)) type_q[w*32 +: 32] <= reg_wdata;
                    if (reg_addr == ADDR_W'(A_EN + w))   en_q[w*32 +: 32]   <= reg_wdata;
                end
                for (int e = 0; e < NUM_EVENTS; e++) begin
                    if (reg_addr == ADDR_W'(A_EVMAP + e / 4))
                        evmap_q[e] <= reg_wdata[(e % 4)*8 +: 8];
                end
                for (int c = 0; c < NUM_CHANNELS; c++) begin
                    if (reg_addr == ADDR_W'(A_HMAP + c / 4))
                        hmap_q[c] <= reg_wdata[(c % 4)*8 +: 8];
                end
            end
        end
    end

    // Status clear mask: ones written to a status word in this cycle.
    always_comb begin
        clr_o = '0;
        for (int w = 0; w < EV_WORDS; w++) begin
            if (reg_wr && reg_addr == ADDR_W'(A_STAT + w)) clr_o[w*32 +: 32] = reg_wdata;
        end
    end

    // Read multiplexer, combinational from the word address.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_GLOBAL)) reg_rdata[0] = glob_q;
        if (reg_addr == ADDR_W'(A_HEN))    reg_rdata[NUM_HOSTS-1:0] = hen_q;
        if (reg_addr == ADDR_W'(A_CORE))   reg_rdata = core_word_i;
        for (int w = 0; w < EV_WORDS; w++) begin
            if (reg_addr == ADDR_W'(A_POL + w))  reg_rdata = pol_q[w*32 +: 32];
            if (reg_addr == ADDR_W'(A_TYPE + w)) reg_rdata = type_q[w*32 +: 32];
            if (reg_addr == ADDR_W'(A_STAT + w)) reg_rdata = status_i[w*32 +: 32];
            if (reg_addr == ADDR_W'(A_EN + w))   reg_rdata = en_q[w*32 +: 32];
        end
        for (int e = 0; e < NUM_EVENTS; e++) begin
            if (reg_addr == ADDR_W'(A_EVMAP + e / 4)) reg_rdata[(e % 4)*8 +: 8] = evmap_q[e];
        end
        for (int c = 0; c < NUM_CHANNELS; c++) begin
            if (reg_addr == ADDR_W'(A_HMAP + c / 4)) reg_rdata[(c % 4)*8 +: 8] = hmap_q[c];
        end
    end

    assign glob_en_o = glob_q;
    assign pol_o     = pol_q;
    assign type_o    = type_q;
    assign en_o      = en_q;
    assign evmap_o   = evmap_q;
    assign hmap_o    = hmap_q;
    assign hen_o     = hen_q;
    assign retrig_o  = retrig_q;
endmodule

// File: rtl/mpic_latch.sv
// Module: per-event polarity, edge/level qualification and sticky status.
// Assumes inputs are already synchronous to clk; a new set wins over a clear in the same cycle.
module mpic_latch #(
    parameter int unsigned NUM_EVENTS = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] evt_i,
    input  logic [NUM_EVENTS-1:0] pol_i,
    input  logic [NUM_EVENTS-1:0] type_i,
    input  logic [NUM_EVENTS-1:0] clr_i,
    output logic [NUM_EVENTS-1:0] status_o
);
    for (genvar g = 0; g < NUM_EVENTS; g++) begin : g_evt
        logic act, prev_q, set_now, stat_q;
        assign act     = ~(evt_i[g] ^ pol_i[g]);
        assign set_now = type_i[g] ? (act & ~prev_q) : act;

        // Remember the last active state and hold status until cleared.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                stat_q <= 1'b0;
            end else begin
                prev_q <= act;
                stat_q <= (stat_q & ~clr_i[g]) | set_now;
            end
        end
        assign status_o[g] = stat_q;
    end
endmodule

// File: rtl/mpic_router.sv
// Module: two-stage routing, events to channels then channels to hosts, and host gating.
// Assumes map values at or above the channel/host count match nothing.
module mpic_router #(
    parameter int unsigned NUM_EVENTS   = 64,
    parameter int unsigned NUM_CHANNELS = 10,
    parameter int unsigned NUM_HOSTS    = 10
) (
    input  logic [NUM_EVENTS-1:0]         status_i,
    input  logic [NUM_EVENTS-1:0]         en_i,
    input  logic [NUM_EVENTS-1:0][7:0]    evmap_i,
    input  logic [NUM_CHANNELS-1:0][7:0]  hmap_i,
    input  logic                          glob_en_i,
    input  logic [NUM_HOSTS-1:0]          hen_i,
    input  logic [NUM_HOSTS-1:0]          retrig_i,
    output logic [NUM_HOSTS-1:0]          host_irq_o
);
    logic [NUM_CHANNELS-1:0] chan_pend;
    logic [NUM_HOSTS-1:0]    host_pend;

    for (genvar c = 0; c < NUM_CHANNELS; c++) begin : g_chan
        logic hit;
        // A channel is pending when any enabled, latched event maps to it.
        always_comb begin
            hit = 1'b0;
            for (int e = 0; e < NUM_EVENTS; e++) begin
                if (status_i[e] && en_i[e] && evmap_i[e] == 8'(c)) hit = 1'b1;
            end
        end
        assign chan_pend[c] = hit;
    end

    for (genvar h = 0; h < NUM_HOSTS; h++) begin : g_host
        logic hit;
        // A host is pending when any pending channel maps to it.
        always_comb begin
            hit = 1'b0;
            for (int c = 0; c < NUM_CHANNELS; c++) begin
                if (chan_pend[c] && hmap_i[c] == 8'(h)) hit = 1'b1;
            end
        end
        assign host_pend[h]  = hit;
        assign host_irq_o[h] = glob_en_i & hen_i[h] & ~retrig_i[h] & host_pend[h];
    end
endmodule

// File: rtl/mpic_top.sv
// Module: top of the mapped interrupt controller; wires register file, status latch and router.
// Assumes one clock domain and synchronous active-low reset.
module mpic_top
    import mpic_pkg::*;
#(
    parameter int unsigned NUM_EVENTS   = 64,
    parameter int unsigned NUM_CHANNELS = 10,
    parameter int unsigned NUM_HOSTS    = 10,
    parameter int unsigned ADDR_W       = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] evt_in,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DW-1:0]         reg_wdata,
    output logic [DW-1:0]         reg_rdata,
    output logic [NUM_HOSTS-1:0]  host_irq,
    output logic [DW-1:0]         core_status
);
    logic                         glob_en;
    logic [NUM_EVENTS-1:0]        pol, typ, en, clr, evt_status;
    logic [NUM_EVENTS-1:0][7:0]   evmap;
    logic [NUM_CHANNELS-1:0][7:0] hmap;
    logic [NUM_HOSTS-1:0]         hen, retrig;

    // Polled word: the two lowest hosts in the top two bits.
    always_comb begin
        core_status              = '0;
        core_status[CORE_BIT_H0] = host_irq[0];
        core_status[CORE_BIT_H1] = host_irq[1];
    end

    mpic_regs #(
        .NUM_EVENTS(NUM_EVENTS), .NUM_CHANNELS(NUM_CHANNELS),
        .NUM_HOSTS(NUM_HOSTS), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status_i(evt_status),
        .core_word_i(core_status), .glob_en_o(glob_en), .pol_o(pol), .type_o(typ),
        .en_o(en), .clr_o(clr), .evmap_o(evmap), .hmap_o(hmap), .hen_o(hen),
        .retrig_o(retrig)
    );

    mpic_latch #(.NUM_EVENTS(NUM_EVENTS)) u_latch (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_in), .pol_i(pol), .type_i(typ),
        .clr_i(clr), .status_o(evt_status)
    );

    mpic_router #(
        .NUM_EVENTS(NUM_EVENTS), .NUM_CHANNELS(NUM_CHANNELS), .NUM_HOSTS(NUM_HOSTS)
    ) u_router (
        .status_i(evt_status), .en_i(en), .evmap_i(evmap), .hmap_i(hmap),
        .glob_en_i(glob_en), .hen_i(hen), .retrig_i(retrig), .host_irq_o(host_irq)
    );
endmodule

// File: rtl/mpic_chk.sv
// Module: protocol checker for mpic_top, attached by bind below.
// Assumes the same parameters and word addresses as the design.
module mpic_chk
    import mpic_pkg::*;
#(
    parameter int unsigned NUM_EVENTS = 64,
    parameter int unsigned NUM_HOSTS  = 10,
    parameter int unsigned ADDR_W     = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic [DW-1:0]         reg_wdata,
    input logic [NUM_HOSTS-1:0]  host_irq,
    input logic                  glob_en,
    input logic [NUM_HOSTS-1:0]  hen,
    input logic [NUM_EVENTS-1:0] status
);
    localparam int unsigned EV_WORDS = NUM_EVENTS / 32;
    localparam int unsigned A_STAT   = A_EVBASE + 2 * EV_WORDS;

    logic stat_wr;
    assign stat_wr = reg_wr && reg_addr >= ADDR_W'(A_STAT) && reg_addr < ADDR_W'(A_STAT + EV_WORDS);

    p_gate_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> host_irq == '0);

    p_host_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq & ~hen) == '0);

    p_clear_only_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status) & ~status)) |-> $past(stat_wr));

    for (genvar h = 0; h < NUM_HOSTS; h++) begin : g_rt
        p_retrig_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == ADDR_W'(A_HIDX) && reg_wdata[7:0] == 8'(h) && hen[h])
            |=> !host_irq[h]);
    end
endmodule

bind mpic_top mpic_chk #(
    .NUM_EVENTS(NUM_EVENTS), .NUM_HOSTS(NUM_HOSTS), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .host_irq(host_irq), .glob_en(glob_en),
    .hen(hen), .status(evt_status)
);

// File: tb/mpic_top_tb.sv
module mpic_top_tb;
    localparam int A_GLB = 0, A_HIDX = 1, A_HEN = 2, A_CORE = 3;
    localparam int A_POL = 8, A_TYP = 10, A_STAT = 12, A_EN = 14, A_EVM = 16, A_HM = 32;
    localparam int NV = 6;
    // {event, channel, host}
    localparam logic [23:0] VEC [NV] = '{
        {8'd0,  8'd0,  8'd0},
        {8'd5,  8'd3,  8'd7},
        {8'd37, 8'd9,  8'd1},
        {8'd63, 8'd4,  8'd9},
        {8'd18, 8'd10, 8'd2},
        {8'd44, 8'd2,  8'd12}
    };

    logic        clk = 0, rst_n = 0, reg_wr = 0;
    logic [63:0] evt = '0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata, core_status, rv;
    logic [9:0]  host_irq;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    mpic_top u_dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_irq(host_irq),
        .core_status(core_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = 6'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 6'(a);
        #1 d = reg_rdata;
    endtask

    task automatic pulse_evt(input int e);
        @(negedge clk); evt[e] = 1;
        @(negedge clk); evt[e] = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 host", 32'(host_irq), 0);
        rd(A_POL, rv);      chk("R1 pol", rv, 32'hffffffff);
        rd(A_TYP, rv);      chk("R1 type", rv, 0);
        rd(A_HEN, rv);      chk("R1 hen", rv, 0);
        rd(A_EVM + 5, rv);  chk("R1 evmap", rv, 0);
        rd(A_STAT, rv);     chk("R1 status", rv, 0);

        // R10 global enable off: status latches, no output
        wr(A_EN, 32'h8);
        wr(A_HIDX, 0);
        pulse_evt(3);
        rd(A_STAT, rv);     chk("R10 latch", rv, 32'h8);
        chk("R10 gated", 32'(host_irq), 0);
        wr(A_GLB, 1);
        chk("R10 enabled", 32'(host_irq), 1);
        rd(A_CORE, rv);     chk("R11 core h0", rv, 32'h4000_0000);
        chk("R11 port", core_status, 32'h4000_0000);

        // R9 re-trigger of an enabled, pending host
        wr(A_HIDX, 0);
        chk("R9 drop", 32'(host_irq), 0);
        @(negedge clk);
        chk("R9 back", 32'(host_irq), 1);
        wr(A_STAT, 32'h8);
        chk("R4 clear", 32'(host_irq), 0);

        // R8 index range and mask readback
        wr(A_HIDX, 12);
        rd(A_HEN, rv);      chk("R8 ignore", rv, 1);
        wr(A_HIDX, 1);
        rd(A_HEN, rv);      chk("R8 set", rv, 3);

        // R12 readback
        wr(A_EVM + 1, 32'h0a0b0c0d);
        rd(A_EVM + 1, rv);  chk("R12 evmap", rv, 32'h0a0b0c0d);
        wr(A_EVM + 1, 0);
        wr(A_EN + 1, 32'h1234_5678);
        rd(A_EN + 1, rv);   chk("R12 en", rv, 32'h1234_5678);
        wr(A_EN + 1, 0);

        // R3 pulse type: one set per edge
        wr(A_TYP, 32'h10);
        @(negedge clk); evt[4] = 1;
        @(negedge clk);
        rd(A_STAT, rv);     chk("R3 edge", rv, 32'h10);
        wr(A_STAT, 32'h10);
        @(negedge clk);
        rd(A_STAT, rv);     chk("R3 held", rv, 0);
        evt[4] = 0;
        @(negedge clk); evt[4] = 1;
        @(negedge clk);
        rd(A_STAT, rv);     chk("R3 re-edge", rv, 32'h10);
        wr(A_STAT, 32'h10);
        evt[4] = 0;
        @(negedge clk);

        // R4 clear and new edge in the same cycle: set wins; zero write no effect
        @(negedge clk);
        evt[4] = 1; reg_wr = 1; reg_addr = 6'(A_STAT); reg_wdata = 32'h10;
        @(negedge clk);
        reg_wr = 0;
        rd(A_STAT, rv);     chk("R4 collide", rv, 32'h10);
        wr(A_STAT, 0);
        rd(A_STAT, rv);     chk("R4 zeros", rv, 32'h10);
        wr(A_STAT, 32'h10);
        rd(A_STAT, rv);     chk("R4 cleared", rv, 0);
        evt[4] = 0;

        // R2 active-low level event
        wr(A_POL, ~32'h40);
        @(negedge clk);
        rd(A_STAT, rv);     chk("R2 active low", rv, 32'h40);
        wr(A_STAT, 32'h40);
        rd(A_STAT, rv);     chk("R2 level relatch", rv, 32'h40);
        evt[6] = 1;
        wr(A_STAT, 32'h40);
        @(negedge clk);
        rd(A_STAT, rv);     chk("R2 inactive", rv, 0);
        evt[6] = 0;
        wr(A_POL, 32'hffffffff);
        wr(A_TYP, 0);
        wr(A_STAT, 32'hffffffff);
        rd(A_STAT, rv);     chk("R2 restore", rv, 0);

        // R5 R6 R7 routing vectors
        for (int i = 0; i < NV; i++) begin
            int e, c, h;
            logic [31:0] exp;
            e = int'(VEC[i][23:16]); c = int'(VEC[i][15:8]); h = int'(VEC[i][7:0]);
            wr(A_EVM + e / 4, 32'(c) << ((e % 4) * 8));
            if (c < 10) wr(A_HM + c / 4, 32'(h) << ((c % 4) * 8));
            wr(A_EN + e / 32, 32'h1 << (e % 32));
            wr(A_HIDX, 32'(h));
            pulse_evt(e);
            exp = (c < 10 && h < 10) ? (32'h1 << h) : 0;
            chk("R5 R6 R7 route", 32'(host_irq), exp);
            if (h == 1 && c < 10) chk("R11 core h1", core_status, 32'h8000_0000);
            wr(A_STAT + e / 32, 32'h1 << (e % 32));
            chk("R4 route clear", 32'(host_irq), 0);
            wr(A_EVM + e / 4, 0);
            if (c < 10) wr(A_HM + c / 4, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule